// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. It has one transmit path and a receive path with two buffers. On the transmit side, a holding buffer feeds a shift engine. On the receive side, a shift engine feeds a register that the CPU reads. Static configuration inputs select the frame shape: 7 or 8 data bits, one of five parity treatments, and one or two stop bits. A clock-source field picks which external timer-underflow pulse stream drives the bit clock. That stream is divided by 8 to form a sample tick, and one bit lasts 8 ticks.

Software uses the port through a narrow register-style interface. A write strobe loads the transmit byte, and a frame goes out on the next tick. Every completed received character is copied into the readable register. A one-cycle interrupt pulse and an available flag mark the copy. A read strobe acknowledges the character, and a separate status-clear strobe clears the overrun flag. Parity and framing problems of the latest character appear on their own flag outputs.

Top module: `sp_async`

## Requirements
- R1: With 8-bit length and no parity, a frame received LSB first (start bit 0, 8 data bits, stop bit 1) appears unchanged on `rd_data`.
- R2: When `cfg_len8`=0 the port sends and receives 7 data bits, and `rd_data[7]` reads 0 whatever the line carried.
- R3: `cfg_par` selects the parity bit that follows the data: 000 none, 100 always 0, 101 always 1, 110 even (data plus parity has an even count of ones), 111 odd. Codes 001 to 011 behave as none. The transmitter inserts the bit. A received mismatch sets `par_err` for that character.
- R4: `cfg_stop2`=0 selects one stop bit and 1 selects two. The transmitter drives every stop bit high. A received 0 at any stop position sets `frm_err` for that character.
- R5: `cfg_clk_src`=01 uses `tmr0_uf` pulses and 11 uses `tmr1_uf` pulses. Every 8 selected pulses give one tick, and each bit lasts 8 ticks.
- R6: `cfg_clk_src` codes 00 and 10 are invalid. While one is selected, `txd` stays 1, the receive line is ignored, and a byte written meanwhile is sent once a valid code returns.
- R7: A `wr_en` strobe loads `wr_data` and starts its frame on the following tick. The frame has a start bit 0 and then the data LSB first.
- R8: When a character completes, `rx_avail` becomes 1, and `rx_irq` pulses for one cycle in the same cycle that the new byte appears on `rd_data`.
- R9: `rd_en` clears `rx_avail`. `rd_data` keeps the character until the next one completes.
- R10: If a character completes while `rx_avail` is 1 and `rd_en` is low, `overrun` becomes 1. It stays 1 until a `stat_clr` strobe clears it.
- R11: A completion in the same cycle as `rd_en` leaves `rx_avail` at 1 without an overrun. A completion that overruns in the same cycle as `stat_clr` leaves `overrun` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr0_uf | input | 1 | Timer 0 underflow pulse |
| tmr1_uf | input | 1 | Timer 1 underflow pulse |
| cfg_clk_src | input | 2 | Tick source select |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par | input | 3 | Parity mode |
| cfg_stop2 | input | 1 | 1: two stop bits |
| wr_en | input | 1 | Load transmit byte strobe |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Receive register read strobe |
| stat_clr | input | 1 | Overrun clear strobe |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| tx_busy | output | 1 | Transmit byte pending or in flight |
| rd_data | output | 8 | Received character |
| rx_avail | output | 1 | Unread character present |
| rx_irq | output | 1 | Receive-complete pulse |
| overrun | output | 1 | Character lost before read |
| par_err | output | 1 | Parity mismatch on latest character |
| frm_err | output | 1 | Stop-bit error on latest character |

## Verification
A receive completion can fall in the same cycle as a software read. It can also fall in the same cycle as a status clear. The bench provokes both by holding `rd_en` high, or `stat_clr` high, across the whole incoming frame. That way the strobe is certainly active at the completing edge. The bench then judges the result relative to the `rx_irq` pulse: the set must win in that cycle, and the held strobe must clear the flag one cycle later.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int OSR = 8;       // ticks per bit
    localparam int DW  = 8;       // max data bits
    localparam int FW  = 12;      // max frame bits
    localparam int SW  = $clog2(OSR);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

    typedef struct packed {
        logic [FW-1:0] bits;
        logic [3:0]    len;
    } frame_t;

    function automatic logic par_bit(input logic [DW-1:0] d, input logic len8,
                                     input logic [2:0] mode);
        logic [DW-1:0] m;
        logic r;
        m = len8 ? d : {1'b0, d[DW-2:0]};
        case (mode[1:0])
            2'b00:   r = 1'b0;
            2'b01:   r = 1'b1;
            2'b10:   r = ^m;
            default: r = ~^m;
        endcase
        return r;
    endfunction

    function automatic logic [3:0] frame_len(input logic len8, input logic [2:0] mode,
                                             input logic stop2);
        return 4'd1 + (len8 ? 4'd8 : 4'd7) + {3'b000, mode[2]} + 4'd1 + {3'b000, stop2};
    endfunction

    function automatic frame_t build_frame(input logic [DW-1:0] d, input logic len8,
                                           input logic [2:0] mode, input logic stop2);
        frame_t f;
        f.bits    = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < DW - 1 || len8) f.bits[i+1] = d[i];
        end
        if (mode[2]) begin
            if (len8) f.bits[9] = par_bit(d, len8, mode);
            else      f.bits[8] = par_bit(d, len8, mode);
        end
        f.len = frame_len(len8, mode, stop2);
        return f;
    endfunction
endpackage

// File: rtl/sp_tick.sv
module sp_tick #(
    parameter int DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uf0,
    input  logic       uf1,
    input  logic [1:0] sel,
    output logic       tick,
    output logic       valid
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tk_t;

    tk_t st_q, st_d;
    logic uf;

    always_comb begin
        valid = sel[0];
        uf    = sel[1] ? uf1 : uf0;
        tick  = valid && uf && (st_q.cnt == CW'(DIV - 1));
        st_d  = st_q;
        if (!valid)  st_d.cnt = '0;
        else if (uf) st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          valid,
    input  logic          len8,
    input  logic [2:0]    par,
    input  logic          stop2,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          txd,
    output logic          busy
);
    localparam logic [SW-1:0] SUB_LAST = SW'(OSR - 1);

    typedef struct packed {
        logic          pend;
        logic [DW-1:0] hold;
        logic          act;
        logic [FW-1:0] sh;
        logic [3:0]    left;
        logic [SW-1:0] sub;
    } tx_t;

    tx_t q, d;
    frame_t f;

    always_comb begin
        d = q;
        f = build_frame(q.hold, len8, par, stop2);
        if (valid && tick) begin
            if (q.act) begin
                d.sub = q.sub + 1'b1;
                if (q.sub == SUB_LAST) begin
                    d.sh   = {1'b1, q.sh[FW-1:1]};
                    d.left = q.left - 1'b1;
                    if (q.left == 4'd1) d.act = 1'b0;
                end
            end else if (q.pend) begin
                d.sh   = f.bits;
                d.left = f.len;
                d.act  = 1'b1;
                d.sub  = '0;
                d.pend = 1'b0;
            end
        end
        if (wr_en) begin
            d.pend = 1'b1;
            d.hold = wr_data;
        end
        txd  = !(valid && q.act) || q.sh[0];
        busy = q.act || q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.sh <= '1;
        end else begin
            q <= d;
        end
    end

    // R6
    frozen_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && q.act) |=> $stable(q.sh));
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          valid,
    input  logic          rxd,
    input  logic          len8,
    input  logic [2:0]    par,
    input  logic          stop2,
    output logic          done,
    output logic [DW-1:0] dout,
    output logic          perr,
    output logic          ferr
);
    localparam logic [SW-1:0] SUB_LAST = SW'(OSR - 1);
    localparam logic [SW-1:0] SUB_MID  = SW'(OSR / 2 - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        rx_st_e        st;
        logic [SW-1:0] sub;
        logic [3:0]    cnt;
        logic [DW-1:0] sh;
        logic          pb;
        logic          fe;
        logic          l8;
        logic [2:0]    pm;
        logic          st2;
        logic          done;
        logic [DW-1:0] dout;
        logic          perr;
        logic          ferr;
    } rx_t;

    rx_t q, d;
    logic [DW-1:0] nsh, nd;
    logic          npb, nfe;
    logic [3:0]    dl, last;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.s1   = rxd;
        d.s2   = q.s1;
        dl     = q.l8 ? 4'd8 : 4'd7;
        last   = frame_len(q.l8, q.pm, q.st2) - 4'd2;
        nsh    = q.sh;
        npb    = q.pb;
        nfe    = q.fe;
        nd     = q.l8 ? nsh : {1'b0, nsh[DW-1:1]};
        if (!valid) begin
            d.st   = RX_IDLE;
            d.prev = 1'b1;
        end else if (tick) begin
            d.prev = q.s2;
            case (q.st)
                RX_IDLE: begin
                    if (q.prev && !q.s2) begin
                        d.st  = RX_START;
                        d.sub = '0;
                        d.l8  = len8;
                        d.pm  = par;
                        d.st2 = stop2;
                    end
                end
                RX_START: begin
                    d.sub = q.sub + 1'b1;
                    if (q.sub == SUB_MID) begin
                        if (!q.s2) begin
                            d.st  = RX_BITS;
                            d.sub = '0;
                            d.cnt = '0;
                            d.fe  = 1'b0;
                            d.pb  = 1'b0;
                        end else begin
                            d.st = RX_IDLE;
                        end
                    end
                end
                default: begin
                    d.sub = q.sub + 1'b1;
                    if (q.sub == SUB_LAST) begin
                        if (q.cnt < dl)                      nsh = {q.s2, q.sh[DW-1:1]};
                        else if (q.pm[2] && q.cnt == dl)     npb = q.s2;
                        else if (!q.s2)                      nfe = 1'b1;
                        d.sh  = nsh;
                        d.pb  = npb;
                        d.fe  = nfe;
                        d.cnt = q.cnt + 1'b1;
                        nd    = q.l8 ? nsh : {1'b0, nsh[DW-1:1]};
                        if (q.cnt == last) begin
                            d.st   = RX_IDLE;
                            d.done = 1'b1;
                            d.dout = nd;
                            d.perr = q.pm[2] && (npb != par_bit(nd, q.l8, q.pm));
                            d.ferr = nfe;
                        end
                    end
                end
            endcase
        end
        done = q.done;
        dout = q.dout;
        perr = q.perr;
        ferr = q.ferr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.s1   <= 1'b1;
            q.s2   <= 1'b1;
            q.prev <= 1'b1;
            q.st   <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    // R6
    rx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !done);
endmodule

// File: rtl/sp_async.sv
module sp_async
    import sp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tmr0_uf,
    input  logic          tmr1_uf,
    input  logic [1:0]    cfg_clk_src,
    input  logic          cfg_len8,
    input  logic [2:0]    cfg_par,
    input  logic          cfg_stop2,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          stat_clr,
    input  logic          rxd,
    output logic          txd,
    output logic          tx_busy,
    output logic [DW-1:0] rd_data,
    output logic          rx_avail,
    output logic          rx_irq,
    output logic          overrun,
    output logic          par_err,
    output logic          frm_err
);
    typedef struct packed {
        logic [DW-1:0] rbuf;
        logic          avail;
        logic          ovr;
        logic          pe;
        logic          fe;
        logic          irq;
    } rf_t;

    rf_t q, d;
    logic          tick, clk_ok;
    logic          rx_done, rx_pe, rx_fe;
    logic [DW-1:0] rx_data;

    sp_tick #(.DIV(OSR)) u_tick (
        .clk(clk), .rst_n(rst_n), .uf0(tmr0_uf), .uf1(tmr1_uf),
        .sel(cfg_clk_src), .tick(tick), .valid(clk_ok)
    );

    sp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .valid(clk_ok),
        .len8(cfg_len8), .par(cfg_par), .stop2(cfg_stop2),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .busy(tx_busy)
    );

    sp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .valid(clk_ok), .rxd(rxd),
        .len8(cfg_len8), .par(cfg_par), .stop2(cfg_stop2),
        .done(rx_done), .dout(rx_data), .perr(rx_pe), .ferr(rx_fe)
    );

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (rd_en)    d.avail = 1'b0;
        if (stat_clr) d.ovr   = 1'b0;
        if (rx_done) begin
            d.rbuf  = rx_data;
            d.pe    = rx_pe;
            d.fe    = rx_fe;
            d.avail = 1'b1;
            d.irq   = 1'b1;
            if (q.avail && !rd_en) d.ovr = 1'b1;
        end
        rd_data  = q.rbuf;
        rx_avail = q.avail;
        rx_irq   = q.irq;
        overrun  = q.ovr;
        par_err  = q.pe;
        frm_err  = q.fe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R8
    irq_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_avail);

    // R10
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_avail));

    // R6
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_ok |-> txd);
endmodule

// File: tb/sp_async_tb.sv
module sp_async_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BC0 = 64;
    localparam int BC1 = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tmr0_uf = 1'b1;
    logic tmr1_uf = 1'b0;
    logic [1:0] cfg_clk_src = 2'b01;
    logic cfg_len8 = 1'b1;
    logic [2:0] cfg_par = 3'b000;
    logic cfg_stop2 = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic rd_en = 1'b0;
    logic stat_clr = 1'b0;
    logic rxd = 1'b1;
    logic txd, tx_busy, rx_avail, rx_irq, overrun, par_err, frm_err;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [9:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tmr1_uf <= ~tmr1_uf;

    sp_async u_dut (
        .clk(clk), .rst_n(rst_n), .tmr0_uf(tmr0_uf), .tmr1_uf(tmr1_uf),
        .cfg_clk_src(cfg_clk_src), .cfg_len8(cfg_len8), .cfg_par(cfg_par),
        .cfg_stop2(cfg_stop2), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .stat_clr(stat_clr), .rxd(rxd), .txd(txd), .tx_busy(tx_busy),
        .rd_data(rd_data), .rx_avail(rx_avail), .rx_irq(rx_irq), .overrun(overrun),
        .par_err(par_err), .frm_err(frm_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic pbit(input logic [7:0] dd, input logic l8, input logic [2:0] pm);
        logic [7:0] m;
        m = l8 ? dd : (dd & 8'h7F);
        case (pm)
            3'b100:  return 1'b0;
            3'b101:  return 1'b1;
            3'b110:  return ^m;
            default: return ~^m;
        endcase
    endfunction

    // bits [11:0] line order, [15:12] length
    function automatic logic [15:0] mkframe(input logic [7:0] dd, input logic l8,
            input logic [2:0] pm, input logic s2, input logic badp, input logic bads);
        logic [11:0] b;
        int n;
        b = '1;
        n = 0;
        b[n] = 1'b0; n++;
        for (int i = 0; i < (l8 ? 8 : 7); i++) begin b[n] = dd[i]; n++; end
        if (pm[2]) begin b[n] = pbit(dd, l8, pm) ^ badp; n++; end
        b[n] = ~bads; n++;
        if (s2) begin b[n] = 1'b1; n++; end
        return {4'(n), b};
    endfunction

    task automatic send_rx(input logic [7:0] dd, input logic badp, input logic bads,
                           input int bc, input bit push);
        logic [15:0] f;
        f = mkframe(dd, cfg_len8, cfg_par, cfg_stop2, badp, bads);
        if (push)
            exp_q.push_back({(cfg_len8 ? dd : {1'b0, dd[6:0]}), badp & cfg_par[2], bads});
        for (int i = 0; i < int'(f[15:12]); i++) begin
            rxd = f[i];
            repeat (bc) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (bc) @(negedge clk);
    endtask

    task automatic tx_observe(input logic [7:0] dd, input int bc, input string tag);
        logic [15:0] f;
        int w;
        int bad;
        f = mkframe(dd, cfg_len8, cfg_par, cfg_stop2, 1'b0, 1'b0);
        w = 0;
        bad = 0;
        while (txd && w < 40 * bc) begin @(negedge clk); w++; end
        chk({tag, " start bit seen"}, int'(txd), 0);
        repeat (bc / 2) @(negedge clk);
        for (int i = 0; i < int'(f[15:12]); i++) begin
            if (txd !== f[i]) bad++;
            repeat (bc) @(negedge clk);
        end
        chk({tag, " frame bits mismatches"}, bad, 0);
    endtask

    task automatic tx_send(input logic [7:0] dd, input int bc, input string tag);
        @(negedge clk);
        wr_data = dd;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        tx_observe(dd, bc, tag);
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_irq(output int seen);
        int w;
        w = 0;
        while (!rx_irq && w < 3000) begin @(negedge clk); w++; end
        seen = rx_irq;
    endtask

    // Scoreboard monitor: pops one expected item per completion
    always @(negedge clk) begin
        if (rst_n && rx_irq) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected completion", 1, 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk("R1 rd_data", int'(rd_data), int'(e[9:2]));
                chk("R3 par_err", int'(par_err), int'(e[1]));
                chk("R4 frm_err", int'(frm_err), int'(e[0]));
                chk("R8 rx_avail with irq", int'(rx_avail), 1);
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int seen;
        int lows;
        repeat (5) @(negedge clk);
        chk("R6 reset txd idle", int'(txd), 1);
        chk("R8 reset rx_avail", int'(rx_avail), 0);
        chk("R10 reset overrun", int'(overrun), 0);
        chk("R8 reset irq", int'(rx_irq), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R7 / R1: 8N1
        tx_send(8'hA5, BC0, "R7 8N1 A5");
        send_rx(8'hA5, 0, 0, BC0, 1);
        chk("R8 avail after frame", int'(rx_avail), 1);
        rd_pulse();
        chk("R9 avail cleared by read", int'(rx_avail), 0);
        chk("R9 data held after read", int'(rd_data), 8'hA5);
        send_rx(8'h3E, 0, 0, BC0, 1);
        rd_pulse();

        // R2: 7-bit
        cfg_len8 = 1'b0;
        tx_send(8'hFF, BC0, "R2 7-bit tx");
        send_rx(8'hFF, 0, 0, BC0, 1);
        chk("R2 bit7 reads zero", int'(rd_data[7]), 0);
        rd_pulse();
        cfg_len8 = 1'b1;

        // R3: parity modes
        cfg_par = 3'b110;
        tx_send(8'h3C, BC0, "R3 even tx");
        send_rx(8'h3D, 0, 0, BC0, 1);
        rd_pulse();
        cfg_par = 3'b111;
        tx_send(8'h3C, BC0, "R3 odd tx");
        send_rx(8'h3C, 1, 0, BC0, 1);
        chk("R3 odd mismatch flag", int'(par_err), 1);
        rd_pulse();
        cfg_par = 3'b100;
        tx_send(8'h81, BC0, "R3 forced0 tx");
        send_rx(8'h81, 1, 0, BC0, 1);
        rd_pulse();
        cfg_par = 3'b101;
        tx_send(8'h81, BC0, "R3 forced1 tx");
        send_rx(8'h81, 0, 0, BC0, 1);
        rd_pulse();
        cfg_par = 3'b000;

        // R4: stop bits
        cfg_stop2 = 1'b1;
        tx_send(8'h5A, BC0, "R4 two stop tx");
        send_rx(8'h5A, 0, 1, BC0, 1);
        chk("R4 framing flag", int'(frm_err), 1);
        rd_pulse();
        send_rx(8'h66, 0, 0, BC0, 1);
        chk("R4 framing clear on good", int'(frm_err), 0);
        rd_pulse();
        cfg_stop2 = 1'b0;

        // R5: timer 1 source
        cfg_clk_src = 2'b11;
        repeat (20) @(negedge clk);
        tx_send(8'hC3, BC1, "R5 tmr1 tx");
        send_rx(8'h96, 0, 0, BC1, 1);
        rd_pulse();

        // R6: invalid source codes
        cfg_clk_src = 2'b00;
        @(negedge clk);
        wr_data = 8'h12;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        lows = 0;
        for (int i = 0; i < 700; i++) begin
            if (!txd) lows++;
            @(negedge clk);
        end
        chk("R6 txd held high", lows, 0);
        send_rx(8'h77, 0, 0, BC0, 0);
        chk("R6 rx ignored", int'(rx_avail), 0);
        cfg_clk_src = 2'b10;
        send_rx(8'h55, 0, 0, BC0, 0);
        chk("R6 rx ignored code 10", int'(rx_avail), 0);
        chk("R6 txd high code 10", int'(txd), 1);
        cfg_clk_src = 2'b01;
        tx_observe(8'h12, BC0, "R6 deferred tx");

        // R10: overrun
        send_rx(8'h11, 0, 0, BC0, 1);
        chk("R10 no overrun on first", int'(overrun), 0);
        send_rx(8'h22, 0, 0, BC0, 1);
        chk("R10 overrun set", int'(overrun), 1);
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        chk("R10 overrun cleared", int'(overrun), 0);
        chk("R10 avail unaffected by clear", int'(rx_avail), 1);
        rd_pulse();

        // R11: read coinciding with completion
        send_rx(8'h33, 0, 0, BC0, 1);
        @(negedge clk);
        rd_en = 1'b1;
        fork
            send_rx(8'h44, 0, 0, BC0, 1);
            begin
                wait_irq(seen);
                chk("R11 irq seen under read", seen, 1);
                chk("R11 avail set wins over read", int'(rx_avail), 1);
                chk("R11 no overrun on read", int'(overrun), 0);
                @(negedge clk);
                chk("R11 held read clears next", int'(rx_avail), 0);
            end
        join
        rd_en = 1'b0;

        // R11: status clear coinciding with overrun
        send_rx(8'h55, 0, 0, BC0, 1);
        @(negedge clk);
        stat_clr = 1'b1;
        fork
            send_rx(8'h66, 0, 0, BC0, 1);
            begin
                wait_irq(seen);
                chk("R11 overrun set wins over clear", int'(overrun), 1);
                @(negedge clk);
                chk("R11 held clear clears next", int'(overrun), 0);
            end
        join
        stat_clr = 1'b0;
        rd_pulse();

        repeat (10) @(negedge clk);
        chk("R8 all expected completions seen", exp_q.size(), 0);
        finish_run();
    end
endmodule